// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a word-wide backing store. It holds 256 sets of four ways, each way carrying one 32-bit word with its own tag, valid bit and dirty bit. A lookup compares the address tag against all four ways of the indexed set at once. A hit completes in the cycle it is presented, and read data is steered out of the matching way by a 4-to-1 select.

A miss picks a victim. The victim is the lowest-numbered invalid way if one exists; otherwise it is the way that has gone unused the longest. If the victim is dirty, its word is written to memory first. The word is then fetched, and the original request is replayed as a hit. Writes stay in the cache until eviction, and a write miss allocates the word before merging the new data.

The processor port is a valid/ready handshake. The requester raises `req_valid` and must hold `req_write`, `req_addr` and `req_wdata` stable until it sees `req_ready` high at a rising clock edge. That edge is the transfer. `req_ready` is never high while `req_valid` is low, and the block may keep it low for as long as a miss is being serviced. The memory port carries one request at a time. `mem_req` and its address and data stay stable until the edge on which `mem_ack` is sampled high. `mem_rdata` is valid in the acknowledging cycle.

Top module: `cache4w_top`

## Requirements
- R1: After reset no way is valid or dirty, and the age order of every set is way 0 youngest through way 3 oldest. With `req_valid` low, `req_ready` and `mem_req` are low, and the first access to any address is a miss.
- R2: The address splits into tag bits [31:10], set index bits [9:2] and byte offset bits [1:0]. Addresses that differ only in the offset reach the same word.
- R3: On a read hit, `req_ready` rises in the same cycle as `req_valid`, and `req_rdata` equals the word held in the matching way. No memory request is made. `req_ready` is never high without `req_valid`.
- R4: A write hit updates only the cached word and marks it dirty, with no memory traffic. A later read of that address returns the new word.
- R5: While any way of a set is invalid, a miss fills the lowest-numbered invalid way and evicts nothing.
- R6: Each way has a 2-bit age, where 0 is youngest. An access sets the touched way to 0 and adds one to every way that was younger than it. When all four ways are valid, the way with age 3 is the victim.
- R7: A dirty victim is written to memory at its own tag and index, with its word, before the refill read is issued.
- R8: A clean victim is replaced with a refill read only, and no memory write is made.
- R9: A write miss fetches the word from memory, then merges the write data into it and marks it dirty. The old memory word is not written back.
- R10: `req_ready` stays low during eviction and refill. A raised `mem_req` keeps its address, direction and data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request completes at this edge |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_rdata | output | 32 | Load data, valid with req_ready |
| mem_req | output | 1 | Memory request held until ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |

## Verification
The hardest case to reach is eviction of a dirty way chosen by age rather than by invalidity. All four ways of one set must first be filled, one must be written, and the others must be touched in a chosen order so that the dirty way ends up oldest. The stimulus table works through a single set in exactly that sequence, and it tracks the expected age order by hand after every access. It then confirms from the memory traffic that a write to the victim's address came before the refill read. Later re-reads of the evicted address show the written-back word coming back from memory.

// File: rtl/cache4w_pkg.sv
package cache4w_pkg;
  typedef enum logic [1:0] {
    ST_LOOK   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/cache4w_store.sv
module cache4w_store #(
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   hit_vec,
  output logic [WAY_W-1:0]  hit_way,
  output logic [DATA_W-1:0] hit_data,
  output logic [WAYS-1:0]   valid_vec,
  input  logic [WAY_W-1:0]  sel_way,
  output logic [TAG_W-1:0]  sel_tag,
  output logic [DATA_W-1:0] sel_data,
  output logic              sel_dirty,
  input  logic              hw_en,
  input  logic [WAY_W-1:0]  hw_way,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   drt_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
      end
    end else begin
      if (hw_en) drt_q[lk_idx][hw_way] <= 1'b1;
      if (fill_en) begin
        vld_q[fill_idx][fill_way] <= 1'b1;
        drt_q[fill_idx][fill_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hw_en) data_q[lk_idx][hw_way] <= hw_data;
    if (fill_en) begin
      tag_q[fill_idx][fill_way]  <= fill_tag;
      data_q[fill_idx][fill_way] <= fill_data;
    end
  end

  assign valid_vec = vld_q[lk_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    hit_data = '0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_data = hit_data | data_q[lk_idx][w];
        hit_way  = hit_way | WAY_W'(w);
      end
    end
  end

  assign sel_tag   = tag_q[lk_idx][sel_way];
  assign sel_data  = data_q[lk_idx][sel_way];
  assign sel_dirty = vld_q[lk_idx][sel_way] && drt_q[lk_idx][sel_way];

  // R2: a tag may live in at most one way of a set
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/cache4w_lru.sv
module cache4w_lru #(
  parameter int SETS = 256,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] touched_age;

  assign touched_age = age_q[idx][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[idx][w] <= '0;
        else if (age_q[idx][w] < touched_age)
          age_q[idx][w] <= age_q[idx][w] + AGE_W'(1);
      end
    end
  end

  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;

  always_comb begin
    any_free   = 1'b0;
    free_way   = '0;
    oldest_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (age_q[idx][w] == AGE_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  assign victim_way = any_free ? free_way : oldest_way;

  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_q[idx][w]] = 1'b1;
  end

  // R6: ages within a set always form a permutation
  assert_ages_permutation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {WAYS{1'b1}});
endmodule

// File: rtl/cache4w_ctrl.sv
module cache4w_ctrl
  import cache4w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 8,
  parameter int WAY_W  = 2,
  localparam int OFF_W = ADDR_W - TAG_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic              hit,
  input  logic [WAY_W-1:0]  victim_way,
  input  logic              victim_dirty,
  input  logic [TAG_W-1:0]  victim_tag,
  input  logic [DATA_W-1:0] victim_data,
  output logic              touch_en,
  output logic              hw_en,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [WAY_W-1:0]  fill_way,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack
);
  ctrl_state_e      state_q, state_d;
  logic [TAG_W-1:0]  m_tag_q, v_tag_q;
  logic [IDX_W-1:0]  m_idx_q;
  logic [WAY_W-1:0]  v_way_q;
  logic [DATA_W-1:0] v_data_q;
  logic              miss_start;

  assign miss_start = (state_q == ST_LOOK) && req_valid && !hit;
  assign req_ready  = (state_q == ST_LOOK) && req_valid && hit;
  assign touch_en   = req_ready;
  assign hw_en      = req_ready && req_write;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOOK:   if (miss_start) state_d = victim_dirty ? ST_EVICT : ST_REFILL;
      ST_EVICT:  if (mem_ack) state_d = ST_REFILL;
      ST_REFILL: if (mem_ack) state_d = ST_LOOK;
      default:   state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_LOOK;
      m_tag_q  <= '0;
      m_idx_q  <= '0;
      v_tag_q  <= '0;
      v_way_q  <= '0;
      v_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (miss_start) begin
        m_tag_q  <= lk_tag;
        m_idx_q  <= lk_idx;
        v_tag_q  <= victim_tag;
        v_way_q  <= victim_way;
        v_data_q <= victim_data;
      end
    end
  end

  assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_REFILL);
  assign mem_we    = (state_q == ST_EVICT);
  assign mem_addr  = (state_q == ST_EVICT) ? {v_tag_q, m_idx_q, {OFF_W{1'b0}}}
                                           : {m_tag_q, m_idx_q, {OFF_W{1'b0}}};
  assign mem_wdata = v_data_q;

  assign fill_en  = (state_q == ST_REFILL) && mem_ack;
  assign fill_idx = m_idx_q;
  assign fill_way = v_way_q;
  assign fill_tag = m_tag_q;

  // R10: an outstanding memory request stays put until acknowledged
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10: no completion while memory traffic is in flight
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  // R3: completion only answers a present request
  assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  // R7: a write-back is always followed by the refill read
  assert_evict_then_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

// File: rtl/cache4w_top.sv
module cache4w_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  lk_idx;
  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic [WAY_W-1:0]  hit_way, victim_way, fill_way;
  logic [TAG_W-1:0]  sel_tag, fill_tag;
  logic [DATA_W-1:0] sel_data;
  logic [IDX_W-1:0]  fill_idx;
  logic              sel_dirty, touch_en, hw_en, fill_en, hit;

  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_idx = req_addr[OFF_W +: IDX_W];
  assign hit    = |hit_vec;

  cache4w_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n, .lk_idx, .lk_tag, .hit_vec, .hit_way, .hit_data(req_rdata),
    .valid_vec, .sel_way(victim_way), .sel_tag, .sel_data, .sel_dirty,
    .hw_en, .hw_way(hit_way), .hw_data(req_wdata),
    .fill_en, .fill_idx, .fill_way, .fill_tag, .fill_data(mem_rdata)
  );

  cache4w_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk, .rst_n, .idx(lk_idx), .valid_vec, .touch_en, .touch_way(hit_way),
    .victim_way
  );

  cache4w_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
                 .WAY_W(WAY_W)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_ready, .lk_tag, .lk_idx, .hit,
    .victim_way, .victim_dirty(sel_dirty), .victim_tag(sel_tag), .victim_data(sel_data),
    .touch_en, .hw_en, .fill_en, .fill_idx, .fill_way, .fill_tag,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack
  );
endmodule

// File: tb/cache4w_top_tb.sv
module cache4w_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache4w_top u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .req_rdata, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
  );

  function automatic logic [31:0] init_word(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [31:0] mk(int t);
    return {22'(t), 8'd5, 2'b00};
  endfunction

  // backing store model
  logic [31:0] bmem [logic [31:0]];
  int n_wr = 0, n_rd = 0, wr_at_rd = -1, lat = 0;
  logic [31:0] last_wa = '0, last_wd = '0;

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (lat == MEM_LAT) begin
        lat = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          last_wa <= mem_addr; last_wd <= mem_wdata;
          wr_at_rd = n_rd; n_wr++;
        end else begin
          mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : init_word(mem_addr);
          n_rd++;
        end
      end else lat++;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  int a_cyc, a_wr, a_rd, a_rd0;
  logic [31:0] a_data;

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd);
    int w0;
    @(negedge clk);
    w0 = n_wr; a_rd0 = n_rd;
    req_valid = 1'b1; req_write = we; req_addr = addr; req_wdata = wd;
    a_cyc = 1;
    #1;
    while (!req_ready) begin
      @(negedge clk); a_cyc++; #1;
    end
    a_data = req_rdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    a_wr = n_wr - w0; a_rd = n_rd - a_rd0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        chk;
    logic        hit;
    logic [3:0]  nwr;
    logic [3:0]  nrd;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [31:0] D1 = 32'hDEAD_0001;
  localparam logic [31:0] D6 = 32'hBEEF_0006;

  localparam vec_t VEC [19] = '{
    '{1'b0, mk(1), 32'h0, init_word(mk(1)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd1}, // R1 cold miss
    '{1'b0, mk(1) | 32'd3, 32'h0, init_word(mk(1)), 1'b1, 1'b1, 4'd0, 4'd0, 4'd2}, // R2 offset ignored, R3 hit
    '{1'b1, mk(1), D1, 32'h0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd4}, // R4 write hit
    '{1'b0, mk(1), 32'h0, D1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd4}, // R4 read back
    '{1'b0, mk(2), 32'h0, init_word(mk(2)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd5}, // R5 fill way 1
    '{1'b0, mk(3), 32'h0, init_word(mk(3)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd5}, // R5 fill way 2
    '{1'b0, mk(4), 32'h0, init_word(mk(4)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd5}, // R5 fill way 3
    '{1'b0, mk(1), 32'h0, D1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd5}, // R5 nothing evicted
    '{1'b0, mk(2), 32'h0, init_word(mk(2)), 1'b1, 1'b1, 4'd0, 4'd0, 4'd6}, // R6 touch
    '{1'b0, mk(5), 32'h0, init_word(mk(5)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd8}, // R8 clean evict of tag3
    '{1'b0, mk(2), 32'h0, init_word(mk(2)), 1'b1, 1'b1, 4'd0, 4'd0, 4'd6}, // R6 survivor
    '{1'b0, mk(4), 32'h0, init_word(mk(4)), 1'b1, 1'b1, 4'd0, 4'd0, 4'd6}, // R6 survivor
    '{1'b0, mk(1), 32'h0, D1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd6}, // R6 survivor
    '{1'b0, mk(3), 32'h0, init_word(mk(3)), 1'b1, 1'b0, 4'd0, 4'd1, 4'd6}, // R6 tag3 gone, evicts tag5
    '{1'b1, mk(6), D6, 32'h0, 1'b0, 1'b0, 4'd0, 4'd1, 4'd9}, // R9 write miss evicts tag2
    '{1'b0, mk(6), 32'h0, D6, 1'b1, 1'b1, 4'd0, 4'd0, 4'd9}, // R9 merged
    '{1'b0, mk(4), 32'h0, init_word(mk(4)), 1'b1, 1'b1, 4'd0, 4'd0, 4'd6}, // R6 touch
    '{1'b0, mk(7), 32'h0, init_word(mk(7)), 1'b1, 1'b0, 4'd1, 4'd1, 4'd7}, // R7 dirty tag1 evicted
    '{1'b0, mk(1), 32'h0, D1, 1'b1, 1'b0, 4'd0, 4'd1, 4'd7}  // R7 written-back word returns
  };

  initial begin
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!req_ready && !mem_req, "R1 idle after reset", {30'd0, req_ready, mem_req}, 32'd0);

    foreach (VEC[i]) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].wdata);
      rq = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      check((a_cyc == 1) == VEC[i].hit, {rq, " hit"}, 32'(a_cyc), VEC[i].hit ? 32'd1 : 32'd2);
      if (VEC[i].chk) check(a_data == VEC[i].exp, {rq, " data"}, a_data, VEC[i].exp);
      check(a_wr == int'(VEC[i].nwr), {rq, " mem writes"}, 32'(a_wr), 32'(VEC[i].nwr));
      check(a_rd == int'(VEC[i].nrd), {rq, " mem reads"}, 32'(a_rd), 32'(VEC[i].nrd));
      if (!VEC[i].hit) check(a_cyc > 2, {"R10 ready held low ", rq}, 32'(a_cyc), 32'd3);
      if (VEC[i].nwr != 0) begin
        check(wr_at_rd == a_rd0, {"R7 write before refill ", rq}, 32'(wr_at_rd), 32'(a_rd0));
        check(last_wa == mk(1), {"R7 write-back address ", rq}, last_wa, mk(1));
        check(last_wd == D1, {"R7 write-back data ", rq}, last_wd, D1);
      end
    end

    // R9: the write-allocate fetch left memory untouched for the written word
    check(!bmem.exists(mk(6)), "R9 no memory write on write miss", 32'(bmem.exists(mk(6))), 32'd0);

    // R1: reset drops all lines
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    access(1'b0, mk(7), 32'h0);
    check(a_cyc > 1, "R1 miss after reset", 32'(a_cyc), 32'd2);
    check(a_wr == 0, "R1 no dirty lines after reset", 32'(a_wr), 32'd0);
    check(a_data == init_word(mk(7)), "R1 refill data", a_data, init_word(mk(7)));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule